// File: doc/BRIEF.md
# Status Flag and Bit-Transfer Unit

This block owns an 8-bit processor status word holding eight flags: global interrupt enable (I), bit-transfer (T), half carry (H), sign (S), two's complement overflow (V), negative (N), zero (Z) and carry (C). It carries out explicit flag instructions: a generic set or clear of the flag chosen by a bit index, and a dedicated set and clear for each named flag. It also moves single bits between a general register and the T flag. A bit-store copies a chosen source bit into T. A bit-load writes T into a chosen bit of a register byte and hands that byte back with a write enable. Each of these finishes in one clock.

Other units, mainly the ALU, send flag updates as a mask and a value. The unit merges them into the status word in the same cycle. When an explicit flag instruction and an ALU update hit the same bit in the same cycle, the explicit instruction decides that bit. The I flag is also driven out as the global interrupt enable.

Top module: `sfu_flag_unit`

## Requirements
- R1: While reset is asserted, and after it is released with no update applied, the status word reads 8'h00 (I=7, T=6, H=5, S=4, V=3, N=2, Z=1, C=0).
- R2: Opcode 5'd1 (indexed set) makes status bit `bit_idx_i` 1 at the next clock edge.
- R3: Opcode 5'd2 (indexed clear) makes status bit `bit_idx_i` 0 at the next clock edge.
- R4: Opcodes 5'd8+k set flag k and opcodes 5'd16+k clear flag k, for k in 0..7 by the bit layout of R1. No other flag changes unless an ALU update addresses it.
- R5: Opcode 5'd3 (bit-store) copies `reg_data_i[bit_idx_i]` into T at the next clock edge.
- R6: Opcode 5'd4 (bit-load) drives `wr_en_o`=1 in the same cycle. `wr_data_o` equals `reg_data_i` with bit `bit_idx_i` replaced by the current T. The instruction itself writes no flag.
- R7: `wr_en_o` is 0 for every opcode other than 5'd4.
- R8: An ALU update loads `alu_val_i` into each status bit whose `alu_mask_i` bit is 1. Bits that an explicit flag instruction addresses in the same cycle take the instruction's value instead.
- R9: Opcodes 0, 5 to 7 and 24 to 31 leave the status word unchanged apart from ALU updates.
- R10: `int_en_o` always equals the I flag, so setting I enables interrupts and clearing I disables them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| op_i | input | 5 | Operation code |
| bit_idx_i | input | 3 | Flag or register bit index |
| reg_data_i | input | 8 | Register operand (bit-store source, bit-load destination) |
| alu_mask_i | input | 8 | Flags the ALU updates this cycle |
| alu_val_i | input | 8 | New values for the masked flags |
| sreg_o | output | 8 | Status word |
| int_en_o | output | 1 | Global interrupt enable (I flag) |
| wr_data_o | output | 8 | Register byte modified by a bit-load |
| wr_en_o | output | 1 | Write enable for `wr_data_o` |

## Verification
The bench targets an explicit instruction and an ALU update landing on the same flag. A design with the priority reversed lets the ALU value win. It also drives a bit-load that follows a bit-store on the next cycle. A design that reads T from the wrong stage returns the stale T. Indices 0 and 7 are swept on the indexed and named instructions, which catches a layout that is shifted or mirrored. Undefined opcodes and bit-loads are checked to leave every flag unchanged. A decoder that treats undefined opcodes as sets, or a bit-load that disturbs the flags, shows up as a status word that differs from the model.

// File: rtl/sfu_pkg.sv
package sfu_pkg;
  localparam int unsigned SW_W   = 8;
  localparam int unsigned IDX_W  = $clog2(SW_W);
  localparam int unsigned OP_W   = 5;

  localparam int unsigned FL_C = 0;
  localparam int unsigned FL_Z = 1;
  localparam int unsigned FL_N = 2;
  localparam int unsigned FL_V = 3;
  localparam int unsigned FL_S = 4;
  localparam int unsigned FL_H = 5;
  localparam int unsigned FL_T = 6;
  localparam int unsigned FL_I = 7;

  typedef enum logic [OP_W-1:0] {
    OP_NOP    = 5'd0,
    OP_FSET   = 5'd1,
    OP_FCLR   = 5'd2,
    OP_BSTORE = 5'd3,
    OP_BLOAD  = 5'd4
  } sfu_op_e;

  // named set: 2'b01 in the top bits, named clear: 2'b10, flag index below
  localparam logic [1:0] GRP_NSET = 2'b01;
  localparam logic [1:0] GRP_NCLR = 2'b10;
endpackage

// File: rtl/sfu_op_decode.sv
module sfu_op_decode
  import sfu_pkg::*;
#(
  parameter int unsigned W  = SW_W,
  parameter int unsigned IW = IDX_W
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [IW-1:0]   idx_i,
  input  logic [W-1:0]    data_i,
  output logic [W-1:0]    xmask_o,
  output logic [W-1:0]    xval_o,
  output logic            bload_o
);
  localparam int unsigned GW = OP_W - IW;

  logic [GW-1:0] grp;
  logic [W-1:0]  idx_hot;
  logic [W-1:0]  sel_hot;

  assign grp = op_i[OP_W-1:IW];

  generate
    for (genvar k = 0; k < W; k++) begin : g_hot
      assign idx_hot[k] = (idx_i == IW'(k));
      assign sel_hot[k] = (op_i[IW-1:0] == IW'(k));
    end
  endgenerate

  always_comb begin
    xmask_o = '0;
    xval_o  = '0;
    bload_o = 1'b0;
    if (grp == GW'(GRP_NSET)) begin
      xmask_o = sel_hot;
      xval_o  = '1;
    end else if (grp == GW'(GRP_NCLR)) begin
      xmask_o = sel_hot;
    end else if (grp == '0) begin
      unique case (op_i)
        OP_FSET: begin
          xmask_o = idx_hot;
          xval_o  = '1;
        end
        OP_FCLR: xmask_o = idx_hot;
        OP_BSTORE: begin
          xmask_o[FL_T] = 1'b1;
          xval_o[FL_T]  = data_i[idx_i];
        end
        OP_BLOAD: bload_o = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sfu_bit_move.sv
module sfu_bit_move
  import sfu_pkg::*;
#(
  parameter int unsigned W  = SW_W,
  parameter int unsigned IW = IDX_W
) (
  input  logic          bload_i,
  input  logic [IW-1:0] idx_i,
  input  logic [W-1:0]  data_i,
  input  logic          t_i,
  output logic [W-1:0]  wr_data_o,
  output logic          wr_en_o
);
  always_comb begin
    wr_data_o = data_i;
    for (int k = 0; k < W; k++) begin
      if (idx_i == IW'(k)) wr_data_o[k] = t_i;
    end
    wr_en_o = bload_i;
  end
endmodule

// File: rtl/sfu_status_reg.sv
module sfu_status_reg
  import sfu_pkg::*;
#(
  parameter int unsigned W = SW_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] xmask_i,
  input  logic [W-1:0] xval_i,
  input  logic [W-1:0] amask_i,
  input  logic [W-1:0] aval_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_d;
  logic [W-1:0] q_r;
  logic         q_en;

  always_comb begin
    q_en = |(xmask_i | amask_i);
    for (int k = 0; k < W; k++) begin
      if (xmask_i[k])      q_d[k] = xval_i[k];
      else if (amask_i[k]) q_d[k] = aval_i[k];
      else                 q_d[k] = q_r[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_r <= '0;
    else if (q_en) q_r <= q_d;
  end

  assign q_o = q_r;
endmodule

// File: rtl/sfu_flag_unit.sv
module sfu_flag_unit
  import sfu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OP_W-1:0]  op_i,
  input  logic [IDX_W-1:0] bit_idx_i,
  input  logic [SW_W-1:0]  reg_data_i,
  input  logic [SW_W-1:0]  alu_mask_i,
  input  logic [SW_W-1:0]  alu_val_i,
  output logic [SW_W-1:0]  sreg_o,
  output logic             int_en_o,
  output logic [SW_W-1:0]  wr_data_o,
  output logic             wr_en_o
);
  logic [SW_W-1:0] xmask;
  logic [SW_W-1:0] xval;
  logic            bload;

  sfu_op_decode #(.W(SW_W), .IW(IDX_W)) u_dec (
    .op_i    (op_i),
    .idx_i   (bit_idx_i),
    .data_i  (reg_data_i),
    .xmask_o (xmask),
    .xval_o  (xval),
    .bload_o (bload)
  );

  sfu_status_reg #(.W(SW_W)) u_sreg (
    .clk     (clk),
    .rst_n   (rst_n),
    .xmask_i (xmask),
    .xval_i  (xval),
    .amask_i (alu_mask_i),
    .aval_i  (alu_val_i),
    .q_o     (sreg_o)
  );

  sfu_bit_move #(.W(SW_W), .IW(IDX_W)) u_move (
    .bload_i   (bload),
    .idx_i     (bit_idx_i),
    .data_i    (reg_data_i),
    .t_i       (sreg_o[FL_T]),
    .wr_data_o (wr_data_o),
    .wr_en_o   (wr_en_o)
  );

  assign int_en_o = sreg_o[FL_I];
endmodule

// File: rtl/sfu_flag_unit_chk.sv
module sfu_flag_unit_chk
  import sfu_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [OP_W-1:0]  op_i,
  input logic [IDX_W-1:0] bit_idx_i,
  input logic [SW_W-1:0]  reg_data_i,
  input logic [SW_W-1:0]  alu_mask_i,
  input logic [SW_W-1:0]  sreg_o,
  input logic             int_en_o,
  input logic [SW_W-1:0]  wr_data_o,
  input logic             wr_en_o
);
  logic [SW_W-1:0] keep_mask;
  assign keep_mask = ~(SW_W'(1) << bit_idx_i);

  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_zero_chk: assert (sreg_o == '0);
    end
  end

  // R2
  idx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_FSET) |=> sreg_o[$past(bit_idx_i)] == 1'b1);

  // R3
  idx_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_FCLR) |=> sreg_o[$past(bit_idx_i)] == 1'b0);

  // R5
  bit_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_BSTORE) |=> sreg_o[FL_T] == $past(reg_data_i[bit_idx_i]));

  // R6
  bit_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_BLOAD) |-> (wr_en_o && wr_data_o[bit_idx_i] == sreg_o[FL_T]
      && ((wr_data_o ^ reg_data_i) & keep_mask) == '0));

  // R7
  no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i != OP_BLOAD) |-> !wr_en_o);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_i == OP_NOP || op_i == OP_BLOAD) && alu_mask_i == '0) |=> $stable(sreg_o));

  // R10
  int_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_en_o == sreg_o[FL_I]);
endmodule

bind sfu_flag_unit sfu_flag_unit_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_i       (op_i),
  .bit_idx_i  (bit_idx_i),
  .reg_data_i (reg_data_i),
  .alu_mask_i (alu_mask_i),
  .sreg_o     (sreg_o),
  .int_en_o   (int_en_o),
  .wr_data_o  (wr_data_o),
  .wr_en_o    (wr_en_o)
);

// File: tb/tb_sfu_flag_unit.sv
module tb_sfu_flag_unit;
  localparam time CLK_PERIOD = 10ns;

  logic       clk;
  logic       rst_n;
  logic [4:0] op_i;
  logic [2:0] bit_idx_i;
  logic [7:0] reg_data_i;
  logic [7:0] alu_mask_i;
  logic [7:0] alu_val_i;
  logic [7:0] sreg_o;
  logic       int_en_o;
  logic [7:0] wr_data_o;
  logic       wr_en_o;

  int n_run;
  int n_fail;
  bit [7:0] ref_sreg;
  bit done;

  sfu_flag_unit dut (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .bit_idx_i(bit_idx_i),
    .reg_data_i(reg_data_i), .alu_mask_i(alu_mask_i), .alu_val_i(alu_val_i),
    .sreg_o(sreg_o), .int_en_o(int_en_o), .wr_data_o(wr_data_o), .wr_en_o(wr_en_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // behavioural next state of the reference status word
  function automatic bit [7:0] model_next(bit [7:0] cur, int op, int idx,
                                          bit [7:0] data, bit [7:0] am, bit [7:0] av);
    bit [7:0] nxt;
    nxt = cur;
    for (int k = 0; k < 8; k++) if (am[k]) nxt[k] = av[k];
    if (op == 1) nxt[idx] = 1'b1;
    else if (op == 2) nxt[idx] = 1'b0;
    else if (op == 3) nxt[6] = data[idx];
    else if (op >= 8 && op < 16) nxt[op - 8] = 1'b1;
    else if (op >= 16 && op < 24) nxt[op - 16] = 1'b0;
    return nxt;
  endfunction

  // apply one cycle of stimulus at the falling edge, compare, then advance the model
  task automatic step(input string req, input int op, input int idx,
                      input bit [7:0] data, input bit [7:0] am, input bit [7:0] av);
    bit [7:0] exp_wd;
    op_i = 5'(op); bit_idx_i = 3'(idx); reg_data_i = data;
    alu_mask_i = am; alu_val_i = av;
    #1;
    exp_wd = data;
    exp_wd[idx] = ref_sreg[6];
    chk(req, "sreg", sreg_o, ref_sreg);
    chk("R10", "int_en", int_en_o, ref_sreg[7]);
    chk((op == 4) ? "R6" : "R7", "wr_en", wr_en_o, (op == 4));
    if (op == 4) chk("R6", "wr_data", wr_data_o, exp_wd);
    @(posedge clk);
    ref_sreg = model_next(ref_sreg, op, idx, data, am, av);
    @(negedge clk);
  endtask

  initial begin
    n_run = 0; n_fail = 0; ref_sreg = '0; done = 0;
    rst_n = 1'b0; op_i = '0; bit_idx_i = '0; reg_data_i = '0;
    alu_mask_i = '0; alu_val_i = '0;
    repeat (3) @(negedge clk);
    chk("R1", "sreg in reset", sreg_o, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    step("R1", 0, 0, 8'h00, 8'h00, 8'h00);

    // R2 / R3 indexed set and clear, every index including 0 and 7
    for (int i = 0; i < 8; i++) step("R2", 1, i, 8'h00, 8'h00, 8'h00);
    step("R2", 0, 0, 8'h00, 8'h00, 8'h00);
    chk("R2", "all set", sreg_o, 8'hFF);
    for (int i = 7; i >= 0; i--) step("R3", 2, i, 8'h00, 8'h00, 8'h00);
    step("R3", 0, 0, 8'h00, 8'h00, 8'h00);
    chk("R3", "all clear", sreg_o, 8'h00);

    // R4 named set / clear, one flag at a time
    for (int k = 0; k < 8; k++) begin
      step("R4", 8 + k, 0, 8'h00, 8'h00, 8'h00);
      step("R4", 0, 0, 8'h00, 8'h00, 8'h00);
      chk("R4", "named set only own", sreg_o, 1 << k);
      step("R4", 16 + k, 0, 8'h00, 8'h00, 8'h00);
    end
    step("R4", 0, 0, 8'h00, 8'h00, 8'h00);

    // R10 interrupt enable follows I
    step("R10", 15, 0, 8'h00, 8'h00, 8'h00);
    step("R10", 0, 0, 8'h00, 8'h00, 8'h00);
    chk("R10", "int_en after set I", int_en_o, 1);
    step("R10", 23, 0, 8'h00, 8'h00, 8'h00);
    step("R10", 0, 0, 8'h00, 8'h00, 8'h00);
    chk("R10", "int_en after clear I", int_en_o, 0);

    // R5 / R6 bit-store then bit-load back to back
    step("R5", 3, 7, 8'h80, 8'h00, 8'h00);
    step("R6", 4, 0, 8'h00, 8'h00, 8'h00);
    chk("R6", "T moved into bit 0", wr_data_o, 8'h01);
    step("R5", 3, 2, 8'hFB, 8'h00, 8'h00);
    step("R6", 4, 5, 8'hFF, 8'h00, 8'h00);
    step("R6", 4, 3, 8'hA5, 8'hFF, 8'h5A);

    // R8 conflicts between ALU and explicit instruction
    step("R8", 2, 1, 8'h00, 8'h02, 8'h02);
    step("R8", 0, 0, 8'h00, 8'h00, 8'h00);
    chk("R8", "explicit clear beats ALU", sreg_o[1], 0);
    step("R8", 8, 0, 8'h00, 8'h0F, 8'h00);
    step("R8", 3, 0, 8'h00, 8'h40, 8'h40);
    step("R8", 0, 0, 8'h00, 8'hC3, 8'h81);

    // R9 undefined opcodes
    step("R9", 9, 0, 8'h00, 8'h00, 8'h00);
    for (int op = 5; op < 8; op++) step("R9", op, op, 8'hFF, 8'h00, 8'h00);
    for (int op = 24; op < 32; op++) step("R9", op, op & 7, 8'hFF, 8'h00, 8'h00);
    step("R9", 0, 0, 8'h00, 8'h00, 8'h00);

    // mixed traffic
    for (int n = 0; n < 400; n++)
      step("R8", int'($urandom_range(0, 31)), int'($urandom_range(0, 7)),
           8'($urandom), 8'($urandom) & 8'($urandom), 8'($urandom));

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule